// File: doc/BRIEF.md
# Interruptible Iterative Divider

A sequential integer and fractional divider that develops one quotient bit per enabled step. It accepts a dividend up to twice the divisor width and a divisor of `DW` bits. It handles three forms: a single-width integer divide, a double-width-by-single-width integer divide, and a fractional divide that yields a Q1.15 quotient. Integer forms can be signed or unsigned. Fractional division is always signed.

A start strobe captures the operands and the mode. The divider then runs a fixed schedule of `DW + 3` enabled steps, which is 19 steps at the default width:

- one setup step, which takes operand magnitudes and signs;
- `DW` non-restoring iteration steps;
- one remainder-correction step;
- one sign-correction step.

The partial remainder and the quotient sit in the same registers that drive the outputs. Dropping the step-enable freezes the whole computation, and raising it again continues from the same point with nothing lost. A done flag pulses once when the schedule finishes. A divide-by-zero flag reports a zero divisor for the operation in flight.

Top module: `iter_divider`

## Requirements
- R1: After reset, `done`, `div_zero`, `quotient` and `remainder` are all zero.
- R2: With `op_long=0` and `op_frac=0`, the divider divides `dividend[DW-1:0]` by `divisor`. With `op_signed=1` both operands are two's complement, the quotient truncates toward zero, and the remainder carries the dividend's sign. With `op_signed=0` both operands are unsigned. `dividend[2*DW-1:DW]` has no effect in this form.
- R3: With `op_long=1` and `op_frac=0`, the full `2*DW`-bit dividend is divided by `divisor`, signed or unsigned as in R2. The results are exact whenever the true quotient fits in `DW` bits.
- R4: With `op_frac=1`, `op_long` and `op_signed` are ignored. The block returns the truncated signed quotient of `dividend[DW-1:0] * 2^(DW-1) / divisor`, with a remainder of the dividend's sign. The results are exact when the dividend magnitude is below the divisor magnitude.
- R5: A start strobe that finds the divider idle is accepted on that clock edge. With `step_en` held high, `done` is high after the 19th following edge (`DW+3` in general) and is low again after the next edge.
- R6: An edge at which the divider is busy and `step_en` is low performs no step. `quotient` and `remainder` stay unchanged, and `done` is delayed by exactly the number of such edges. The final results equal those of an uninterrupted run.
- R7: `div_zero` is updated only when a start is accepted, and it then equals (`divisor == 0`). After a zero-divisor operation finishes, `quotient` and `remainder` hold steady values.
- R8: A start strobe while the divider is busy is ignored. The running operation keeps its operands and its timing.
- R9: After `done`, `quotient` and `remainder` keep their values until the next accepted start, whatever `step_en` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide (accepted only when idle) |
| step_en | input | 1 | Allows one schedule step per edge while busy |
| op_long | input | 1 | Selects the double-width dividend form |
| op_signed | input | 1 | Two's complement operands for the integer forms |
| op_frac | input | 1 | Selects fractional division |
| dividend | input | 2*DW | Dividend; the low DW bits are used in the single-width and fractional forms |
| divisor | input | DW | Divisor |
| quotient | output | DW | Quotient register (partial while busy, final after done) |
| remainder | output | DW | Remainder register (partial while busy, final after done) |
| done | output | 1 | One-cycle pulse after the last step |
| div_zero | output | 1 | The accepted divisor was zero |

## Verification
The bench builds the divider with `DW = 16` and fractional support enabled. This gives the 19-step schedule and makes the 16-bit boundary operands reachable:

- the most negative single-width dividend;
- a full-scale unsigned quotient;
- a double-width dividend whose quotient exactly fills 16 bits.

At this width the Q1.15 fractional scaling also applies exactly as specified. Pauses and a foreign start strobe are injected at chosen step counts, so both the done cycle and the frozen register contents can be predicted from the step count alone.

// File: rtl/iterdiv_pkg.sv
`timescale 1ns/1ps
package iterdiv_pkg;

   typedef struct packed {
      logic is_long;
      logic is_signed;
      logic is_frac;
   } div_mode_t;

   typedef enum logic [1:0] {
      STEP_SETUP = 2'd0,
      STEP_ITER  = 2'd1,
      STEP_RFIX  = 2'd2,
      STEP_SIGN  = 2'd3
   } step_kind_t;

   // steps in one operation: setup, one per quotient bit, remainder fix, sign fix
   function automatic int unsigned sched_len(input int unsigned qbits);
      return qbits + 3;
   endfunction

endpackage

// File: rtl/iterdiv_sequencer.sv
`timescale 1ns/1ps
module iterdiv_sequencer
   import iterdiv_pkg::*;
#(
   parameter int unsigned QBITS = 16
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       step_en,
   output logic       busy,
   output logic       done,
   output logic       accept,
   output logic       adv,
   output step_kind_t kind
);

   localparam int unsigned LAST = sched_len(QBITS) - 1;
   localparam int unsigned CW   = $clog2(LAST + 1);
   localparam logic [CW-1:0] LAST_C  = CW'(LAST);
   localparam logic [CW-1:0] ITEND_C = CW'(QBITS);
   localparam logic [CW-1:0] RFIX_C  = CW'(QBITS + 1);

   logic [CW-1:0] cnt_r;
   logic          busy_r;
   logic          done_r;

   assign busy   = busy_r;
   assign done   = done_r;
   assign accept = !busy_r && start;
   assign adv    = busy_r && step_en;

   always_comb begin
      if (cnt_r == '0)            kind = STEP_SETUP;
      else if (cnt_r <= ITEND_C)  kind = STEP_ITER;
      else if (cnt_r == RFIX_C)   kind = STEP_RFIX;
      else                        kind = STEP_SIGN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_r  <= '0;
         busy_r <= 1'b0;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (accept) begin
            busy_r <= 1'b1;
            cnt_r  <= '0;
         end else if (adv) begin
            if (cnt_r == LAST_C) begin
               busy_r <= 1'b0;
               done_r <= 1'b1;
               cnt_r  <= '0;
            end else begin
               cnt_r <= cnt_r + 1'b1;
            end
         end
      end
   end

   AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_r |=> !done_r);                                            // R5
   AST_LAST_STEP_RAISES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_r && step_en && cnt_r == LAST_C) |=> (done_r && !busy_r)); // R5
   AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_r |-> (cnt_r <= LAST_C));                                   // R5
   AST_PAUSE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_r && !step_en) |=> (busy_r && $stable(cnt_r)));            // R6

endmodule

// File: rtl/iterdiv_operand_prep.sv
`timescale 1ns/1ps
module iterdiv_operand_prep
   import iterdiv_pkg::*;
#(
   parameter int unsigned DW      = 16,
   parameter bit          FRAC_EN = 1'b1
)(
   input  logic [2*DW-1:0] dividend,
   input  logic [DW-1:0]   divisor,
   input  div_mode_t       mode,
   output logic [2*DW-1:0] num_mag,
   output logic [DW-1:0]   den_mag,
   output logic            neg_quot,
   output logic            neg_rem
);

   localparam int unsigned NW = 2 * DW;

   logic          frac_on;
   logic          sgn_on;
   logic [DW-1:0] short_val;
   logic [DW-1:0] s_mag;
   logic          s_neg;
   logic [NW-1:0] l_mag;
   logic          l_neg;
   logic          d_neg;
   logic          n_neg;

   generate
      if (FRAC_EN) begin : g_frac
         assign frac_on = mode.is_frac;
      end else begin : g_no_frac
         assign frac_on = 1'b0;
      end
   endgenerate

   assign sgn_on    = mode.is_signed | frac_on;
   assign short_val = dividend[DW-1:0];
   assign s_neg     = sgn_on & short_val[DW-1];
   assign s_mag     = s_neg ? (~short_val + 1'b1) : short_val;
   assign l_neg     = sgn_on & dividend[NW-1];
   assign l_mag     = l_neg ? (~dividend + 1'b1) : dividend;
   assign d_neg     = sgn_on & divisor[DW-1];
   assign den_mag   = d_neg ? (~divisor + 1'b1) : divisor;

   always_comb begin
      if (frac_on) begin
         num_mag = {1'b0, s_mag, {(DW-1){1'b0}}};
         n_neg   = s_neg;
      end else if (mode.is_long) begin
         num_mag = l_mag;
         n_neg   = l_neg;
      end else begin
         num_mag = {{DW{1'b0}}, s_mag};
         n_neg   = s_neg;
      end
   end

   assign neg_quot = n_neg ^ d_neg;
   assign neg_rem  = n_neg;

endmodule

// File: rtl/iterdiv_nr_step.sv
`timescale 1ns/1ps
module iterdiv_nr_step #(
   parameter int unsigned DW = 16
)(
   input  logic [DW+1:0] p_in,
   input  logic [DW-1:0] q_in,
   input  logic [DW-1:0] d_in,
   output logic [DW+1:0] p_out,
   output logic [DW-1:0] q_out
);

   logic [DW+1:0] p_sh;
   logic [DW+1:0] d_ext;

   assign p_sh  = {p_in[DW:0], q_in[DW-1]};
   assign d_ext = {2'b00, d_in};
   // sign of the partial remainder before the shift picks add or subtract
   assign p_out = p_in[DW+1] ? (p_sh + d_ext) : (p_sh - d_ext);
   assign q_out = {q_in[DW-2:0], ~p_out[DW+1]};

endmodule

// File: rtl/iter_divider.sv
`timescale 1ns/1ps
module iter_divider
   import iterdiv_pkg::*;
#(
   parameter int unsigned DW      = 16,
   parameter bit          FRAC_EN = 1'b1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            step_en,
   input  logic            op_long,
   input  logic            op_signed,
   input  logic            op_frac,
   input  logic [2*DW-1:0] dividend,
   input  logic [DW-1:0]   divisor,
   output logic [DW-1:0]   quotient,
   output logic [DW-1:0]   remainder,
   output logic            done,
   output logic            div_zero
);

   localparam int unsigned PW = DW + 2;
   localparam int unsigned NW = 2 * DW;

   generate
      if (DW < 4) begin : g_bad_width
         $error("iter_divider: DW must be at least 4");
      end
   endgenerate

   logic            busy;
   logic            accept;
   logic            adv;
   step_kind_t      kind;

   logic [NW-1:0]   a_raw_r;
   logic [DW-1:0]   b_raw_r;
   div_mode_t       mode_r;
   logic [PW-1:0]   p_r;
   logic [DW-1:0]   q_r;
   logic [DW-1:0]   d_r;
   logic            negq_r;
   logic            negr_r;
   logic            dz_r;

   logic [NW-1:0]   num_mag;
   logic [DW-1:0]   den_mag;
   logic            neg_quot;
   logic            neg_rem;
   logic [PW-1:0]   p_nx;
   logic [DW-1:0]   q_nx;

   iterdiv_sequencer #(.QBITS(DW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .step_en (step_en),
      .busy    (busy),
      .done    (done),
      .accept  (accept),
      .adv     (adv),
      .kind    (kind)
   );

   iterdiv_operand_prep #(.DW(DW), .FRAC_EN(FRAC_EN)) u_prep (
      .dividend (a_raw_r),
      .divisor  (b_raw_r),
      .mode     (mode_r),
      .num_mag  (num_mag),
      .den_mag  (den_mag),
      .neg_quot (neg_quot),
      .neg_rem  (neg_rem)
   );

   iterdiv_nr_step #(.DW(DW)) u_step (
      .p_in  (p_r),
      .q_in  (q_r),
      .d_in  (d_r),
      .p_out (p_nx),
      .q_out (q_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_raw_r <= '0;
         b_raw_r <= '0;
         mode_r  <= '0;
         p_r     <= '0;
         q_r     <= '0;
         d_r     <= '0;
         negq_r  <= 1'b0;
         negr_r  <= 1'b0;
         dz_r    <= 1'b0;
      end else if (accept) begin
         a_raw_r <= dividend;
         b_raw_r <= divisor;
         mode_r  <= '{is_long: op_long, is_signed: op_signed, is_frac: op_frac};
         dz_r    <= (divisor == '0);
      end else if (adv) begin
         case (kind)
            STEP_SETUP: begin
               p_r    <= {2'b00, num_mag[NW-1:DW]};
               q_r    <= num_mag[DW-1:0];
               d_r    <= den_mag;
               negq_r <= neg_quot;
               negr_r <= neg_rem;
            end
            STEP_ITER: begin
               p_r <= p_nx;
               q_r <= q_nx;
            end
            STEP_RFIX: begin
               if (p_r[PW-1]) p_r <= p_r + {2'b00, d_r};
            end
            STEP_SIGN: begin
               if (negq_r) q_r <= ~q_r + 1'b1;
               if (negr_r) p_r <= ~p_r + 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign quotient  = q_r;
   assign remainder = p_r[DW-1:0];
   assign div_zero  = dz_r;

   AST_PAUSE_FREEZES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step_en) |=> ($stable(q_r) && $stable(p_r) && $stable(d_r)));  // R6
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(a_raw_r) && $stable(b_raw_r) && $stable(mode_r))); // R8
   AST_ZERO_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(dz_r));                                                // R7
   AST_ZERO_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (dz_r == ($past(divisor) == '0)));                              // R7
   AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !accept) |=> ($stable(q_r) && $stable(p_r)));                    // R9

endmodule

// File: tb/iter_divider_test.sv
`timescale 1ns/1ps
module iter_divider_test;

   localparam int unsigned DW    = 16;
   localparam int          STEPS = DW + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          step_en = 1'b1;
   logic          op_long = 1'b0;
   logic          op_signed = 1'b0;
   logic          op_frac = 1'b0;
   logic [31:0]   dividend = '0;
   logic [15:0]   divisor = '0;
   logic [15:0]   quotient;
   logic [15:0]   remainder;
   logic          done;
   logic          div_zero;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   iter_divider #(.DW(DW), .FRAC_EN(1'b1)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .step_en   (step_en),
      .op_long   (op_long),
      .op_signed (op_signed),
      .op_frac   (op_frac),
      .dividend  (dividend),
      .divisor   (divisor),
      .quotient  (quotient),
      .remainder (remainder),
      .done      (done),
      .div_zero  (div_zero)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void model(input logic [31:0] a, input logic [15:0] b,
                                 input bit lng, input bit sgn, input bit frc,
                                 output logic [15:0] q, output logic [15:0] r);
      longint na, nb, qq, rr;
      if (frc) begin
         na = longint'($signed(a[15:0])) * 32768;
         nb = longint'($signed(b));
      end else if (lng) begin
         na = sgn ? longint'($signed(a)) : longint'(a);
         nb = sgn ? longint'($signed(b)) : longint'(b);
      end else begin
         na = sgn ? longint'($signed(a[15:0])) : longint'(a[15:0]);
         nb = sgn ? longint'($signed(b)) : longint'(b);
      end
      qq = na / nb;
      rr = na % nb;
      q = qq[15:0];
      r = rr[15:0];
   endfunction

   // one operation; optional pause window and optional start strobe while busy
   task automatic run_div(input logic [31:0] a, input logic [15:0] b,
                          input bit lng, input bit sgn, input bit frc,
                          input int pause_at, input int pause_len,
                          input bit inject, input string req);
      int k;
      logic [15:0] eq, er, sq, sr;
      @(negedge clk);
      dividend = a; divisor = b; op_long = lng; op_signed = sgn; op_frac = frc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R7", "div_zero after start", {31'd0, div_zero}, {31'd0, (b == 16'd0)});
      k = 0;
      while (done !== 1'b1 && k < 200) begin
         @(negedge clk);
         k++;
         if (pause_len > 0 && k == pause_at) begin
            sq = quotient; sr = remainder;
            step_en = 1'b0;
            for (int i = 0; i < pause_len; i++) begin
               @(negedge clk);
               k++;
               chk("R6", "quotient frozen", {16'd0, quotient}, {16'd0, sq});
               chk("R6", "remainder frozen", {16'd0, remainder}, {16'd0, sr});
            end
            step_en = 1'b1;
         end
         if (inject && k == 7) begin
            dividend = ~a; divisor = b + 16'd3; op_frac = ~frc;
            start = 1'b1;
            @(negedge clk);
            k++;
            start = 1'b0;
            dividend = a; divisor = b; op_frac = frc;
         end
      end
      chk(pause_len > 0 ? "R6" : "R5", "cycles to done", k, STEPS + pause_len);
      if (b != 16'd0) begin
         model(a, b, lng, sgn, frc, eq, er);
         chk(req, "quotient", {16'd0, quotient}, {16'd0, eq});
         chk(req, "remainder", {16'd0, remainder}, {16'd0, er});
      end
      @(negedge clk);
      chk("R5", "done drops after one cycle", {31'd0, done}, 32'd0);
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      chk("R1", "done at reset", {31'd0, done}, 32'd0);
      chk("R1", "div_zero at reset", {31'd0, div_zero}, 32'd0);
      chk("R1", "quotient at reset", {16'd0, quotient}, 32'd0);
      chk("R1", "remainder at reset", {16'd0, remainder}, 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic test_short_unsigned();
      run_div(32'hABCD_03E8, 16'd7, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, "R2");
      run_div(32'h0000_FFFF, 16'd1, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, "R2");
      run_div(32'h1234_8000, 16'hFFFF, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, "R2");
   endtask

   task automatic test_short_signed();
      run_div(32'h0000_0007, 16'd2, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, "R2");
      run_div(32'h0000_FFF9, 16'd2, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, "R2");
      run_div(32'h0000_0007, 16'hFFFE, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, "R2");
      run_div(32'h5555_FFF9, 16'hFFFE, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, "R2");
      run_div(32'h0000_8000, 16'd3, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, "R2");
   endtask

   task automatic test_long();
      run_div(32'h0012_3456, 16'h1234, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0, "R3");
      run_div(32'hFFFE_0001, 16'hFFFF, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0, "R3");
      run_div(32'hFFFE_7960, 16'd7, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0, "R3");
      run_div(32'h0001_86A0, 16'hFFF9, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0, "R3");
   endtask

   task automatic test_frac();
      run_div(32'h0000_2000, 16'h4000, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0, "R4");
      run_div(32'hFFFF_E000, 16'h4000, 1'b1, 1'b0, 1'b1, 0, 0, 1'b0, "R4");
      run_div(32'h0000_2000, 16'hC000, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0, "R4");
      run_div(32'h0000_1000, 16'h3000, 1'b1, 1'b1, 1'b1, 0, 0, 1'b0, "R4");
   endtask

   task automatic test_div_zero();
      logic [15:0] hq, hr;
      run_div(32'h0000_1234, 16'd0, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, "R7");
      chk("R7", "div_zero held after done", {31'd0, div_zero}, 32'd1);
      hq = quotient; hr = remainder;
      repeat (5) @(negedge clk);
      chk("R7", "quotient steady after zero divide", {16'd0, quotient}, {16'd0, hq});
      chk("R7", "remainder steady after zero divide", {16'd0, remainder}, {16'd0, hr});
      run_div(32'h0000_0064, 16'd9, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, "R7");
      chk("R7", "div_zero cleared by nonzero divide", {31'd0, div_zero}, 32'd0);
   endtask

   task automatic test_pause();
      run_div(32'h0000_7531, 16'd123, 1'b0, 1'b1, 1'b0, 5, 4, 1'b0, "R6");
      run_div(32'hFFF0_1234, 16'h7001, 1'b1, 1'b1, 1'b0, 1, 3, 1'b0, "R6");
      run_div(32'h0000_0F00, 16'h2000, 1'b0, 1'b0, 1'b1, 18, 6, 1'b0, "R6");
   endtask

   task automatic test_busy_start();
      run_div(32'h0000_4E20, 16'd37, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1, "R8");
      run_div(32'h0000_0100, 16'h0400, 1'b0, 1'b0, 1'b1, 0, 0, 1'b1, "R8");
   endtask

   task automatic test_hold();
      logic [15:0] hq, hr;
      run_div(32'h0000_03FF, 16'd10, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, "R9");
      hq = quotient; hr = remainder;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         step_en = ~step_en;
      end
      step_en = 1'b1;
      @(negedge clk);
      chk("R9", "quotient held after done", {16'd0, quotient}, {16'd0, hq});
      chk("R9", "remainder held after done", {16'd0, remainder}, {16'd0, hr});
      chk("R9", "no extra done", {31'd0, done}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      test_reset();
      test_short_unsigned();
      test_short_signed();
      test_long();
      test_frac();
      test_div_zero();
      test_pause();
      test_busy_start();
      test_hold();
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule